// File: doc/BRIEF.md
# Reloading Down-Counter with Byte-Wide Access

This block is a 16-bit timer that counts down from a programmable value and reloads itself from a reload latch whenever it passes below zero. Every reload raises a one-cycle interrupt request. The timer is programmed and read over an 8-bit register bus. Each 16-bit quantity is split into a low byte and a high byte, and a temporary byte buffer on each side keeps a 16-bit value coherent across the two bus accesses.

Each count step comes from one of two sources. The first is an internal enable that fires once every 16 system clocks. The second is an edge on an external pin, which is synchronized into the clock domain first, and the active edge can be chosen. A control register selects the count source and the active edge. It also holds a stop bit and a write-mode bit. The write-mode bit decides whether a committed write updates both the reload latch and the counter, or only the latch.

Top module: `reload_timer16`

## Requirements
- R1: After reset the counter and the reload latch both hold 0xFFFF, the control register reads 0x01 (stopped, internal source), and `irq` is 0.
- R2: When not stopped, each count pulse lowers a nonzero counter by exactly one.
- R3: A count pulse that arrives while the counter holds 0x0000 loads the counter from the reload latch and produces exactly one `irq` pulse, high for one clock.
- R4: While control bit 0 (stop) is 1, the counter holds its value and `irq` stays 0.
- R5: With control bit 1 at 0, the counter steps once every 16 clocks, so `irq` pulses are (latch+1)*16 clocks apart.
- R6: With control bit 1 at 1, the counter steps on the pin edge chosen by control bit 2 (0 rising, 1 falling). The pin is synchronized through two flops, and edges of the other polarity do nothing.
- R7: A read at address 1 returns the counter's high byte and captures its low byte at that moment. A later read at address 0 returns that captured byte, even if the counter has moved since.
- R8: A write at address 0 only stores the byte in a buffer and leaves the counter and latch unchanged. A write at address 1 commits {written byte, buffered byte} as one 16-bit value.
- R9: When control bit 3 is 0, a commit loads both the latch and the counter. When it is 1, the commit loads only the latch and the counter keeps counting from its own value.
- R10: If a commit that loads the counter lands in the same cycle as a count pulse at 0x0000, the written value wins and no `irq` is produced.
- R11: Address 2 reads and writes the control register in bits 3:0. Bits 7:4 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (a high-byte read captures the low byte) |
| bus_addr | input | 2 | 0 low byte, 1 high byte, 2 control |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register, combinational |
| ext_pin | input | 1 | External count pin, asynchronous |
| irq | output | 1 | Underflow request, one-clock pulse |

## Verification
Two functions can fall in the same cycle: a write that loads the counter, and a count pulse that would otherwise underflow it. The bench raises the external pin and then places a high-byte write exactly on the edge where the synchronized pulse is consumed, while the counter holds zero. The expected result is the written value in the counter with no interrupt pulse. Both are judged at the ports through a coherent 16-bit read and an interrupt tally.

// File: rtl/rt_pkg.sv
// Package: shared constants for the reloading timer.
// Assumes an 8-bit bus with a 2-bit address and a 4-bit control register.
package rt_pkg;
    localparam int BYTE_W = 8;
    localparam int CTRL_W = 4;

    // Control bit positions
    localparam int CB_STOP      = 0;
    localparam int CB_SRC_EXT   = 1;
    localparam int CB_EDGE_FALL = 2;
    localparam int CB_LAT_ONLY  = 3;

    localparam logic [CTRL_W-1:0] CTRL_RESET = 4'b0001;

    typedef enum logic [1:0] {
        A_LOW  = 2'd0,
        A_HIGH = 2'd1,
        A_CTRL = 2'd2,
        A_NONE = 2'd3
    } reg_addr_e;
endpackage

// File: rtl/rt_prescale.sv
// Module: free-running divider that makes a one-clock enable every DIV clocks.
// Assumes DIV >= 2. It keeps running while the timer is stopped.
module rt_prescale #(
    parameter int DIV = 16
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);

    logic [PW-1:0] phase;

    // Step the phase and wrap it back to zero after the last value.
    always_ff @(posedge clk) begin
        if (!rst_n)            phase <= '0;
        else if (phase == LAST) phase <= '0;
        else                   phase <= phase + 1'b1;
    end

    assign tick = (phase == LAST);

    AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick); // R5
endmodule

// File: rtl/rt_edge_sync.sv
// Module: two-flop synchronizer for the external pin plus a selectable edge detector.
// Assumes the pin is asynchronous. The pulse is one clock long.
module rt_edge_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    input  logic fall_sel,
    output logic edge_pulse
);
    logic s1, s2, s3;

    // Move the pin into the clock domain and keep one older sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1 <= 1'b0;
            s2 <= 1'b0;
            s3 <= 1'b0;
        end else begin
            s1 <= pin;
            s2 <= s1;
            s3 <= s2;
        end
    end

    assign edge_pulse = fall_sel ? (s3 & ~s2) : (s2 & ~s3);

    AST_EDGE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        edge_pulse |=> !edge_pulse); // R6
endmodule

// File: rtl/rt_count_core.sv
// Module: counter, reload latch and underflow flag.
// Assumes a count pulse and a write commit may coincide. The commit wins and
// suppresses the underflow. A reload uses the latch value held before that cycle.
module rt_count_core #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         stop,
    input  logic         load_cnt,
    input  logic         load_lat,
    input  logic [W-1:0] wval,
    output logic [W-1:0] cnt,
    output logic         uflow
);
    logic [W-1:0] latch_q;
    logic         step;

    assign step = tick && !stop;

    // Reload latch: written only by a commit.
    always_ff @(posedge clk) begin
        if (!rst_n)        latch_q <= '1;
        else if (load_lat) latch_q <= wval;
    end

    // Counter: a commit first, then a reload at zero, else a decrement.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt   <= '1;
            uflow <= 1'b0;
        end else begin
            uflow <= 1'b0;
            if (load_cnt) begin
                cnt <= wval;
            end else if (step) begin
                if (cnt == '0) begin
                    cnt   <= latch_q;
                    uflow <= 1'b1;
                end else begin
                    cnt <= cnt - 1'b1;
                end
            end
        end
    end

    AST_DECREMENT: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load_cnt && cnt != '0) |=> (cnt == $past(cnt) - 1'b1)); // R2
    AST_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load_cnt && cnt == '0) |=> (cnt == $past(latch_q) && uflow)); // R3
    AST_STOP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (stop && !load_cnt) |=> ($stable(cnt) && !uflow)); // R4
    AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        load_cnt |=> (cnt == $past(wval) && !uflow)); // R10
    AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        uflow |=> !uflow); // R3
endmodule

// File: rtl/reload_timer16.sv
// Module: top of the reloading 16-bit down-counter with byte-wide bus access.
// Assumes single-cycle bus strobes. Reads are combinational. Reading the high
// byte captures the low byte, and a high-byte write commits with the buffered low byte.
module reload_timer16 #(
    parameter int PRESCALE = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bus_wr,
    input  logic       bus_rd,
    input  logic [1:0] bus_addr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    input  logic       ext_pin,
    output logic       irq
);
    import rt_pkg::*;
    localparam int CW = 2 * BYTE_W;

    logic [CTRL_W-1:0] ctrl;
    logic [BYTE_W-1:0] wr_low_buf;
    logic [BYTE_W-1:0] rd_low_cap;
    logic [CW-1:0]     cnt;
    logic              int_tick, ext_tick, tick;
    logic              commit;
    reg_addr_e         addr;

    assign addr   = reg_addr_e'(bus_addr);
    assign commit = bus_wr && (addr == A_HIGH);

    // Control register and the buffer for the low byte of a write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl       <= CTRL_RESET;
            wr_low_buf <= '0;
        end else if (bus_wr) begin
            if (addr == A_CTRL) ctrl       <= bus_wdata[CTRL_W-1:0];
            if (addr == A_LOW)  wr_low_buf <= bus_wdata;
        end
    end

    // Capture the counter's low byte when its high byte is read.
    always_ff @(posedge clk) begin
        if (!rst_n)                          rd_low_cap <= '1;
        else if (bus_rd && addr == A_HIGH)   rd_low_cap <= cnt[BYTE_W-1:0];
    end

    rt_prescale #(.DIV(PRESCALE)) u_pre (
        .clk(clk), .rst_n(rst_n), .tick(int_tick)
    );

    rt_edge_sync u_edge (
        .clk(clk), .rst_n(rst_n), .pin(ext_pin),
        .fall_sel(ctrl[CB_EDGE_FALL]), .edge_pulse(ext_tick)
    );

    assign tick = ctrl[CB_SRC_EXT] ? ext_tick : int_tick;

    rt_count_core #(.W(CW)) u_core (
        .clk(clk), .rst_n(rst_n), .tick(tick), .stop(ctrl[CB_STOP]),
        .load_cnt(commit && !ctrl[CB_LAT_ONLY]), .load_lat(commit),
        .wval({bus_wdata, wr_low_buf}), .cnt(cnt), .uflow(irq)
    );

    // Read multiplexer.
    always_comb begin
        case (addr)
            A_LOW:   bus_rdata = rd_low_cap;
            A_HIGH:  bus_rdata = cnt[CW-1:BYTE_W];
            A_CTRL:  bus_rdata = {{(BYTE_W-CTRL_W){1'b0}}, ctrl};
            default: bus_rdata = '0;
        endcase
    end

    AST_LOW_WRITE_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && addr == A_LOW && ctrl[CB_STOP]) |=> $stable(cnt)); // R8
    AST_CTRL_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == A_CTRL) |-> (bus_rdata[BYTE_W-1:CTRL_W] == '0)); // R11
endmodule

// File: tb/reload_timer16_bench.sv
module reload_timer16_bench;
    logic       clk = 0;
    logic       rst_n = 0;
    logic       bus_wr = 0, bus_rd = 0;
    logic [1:0] bus_addr = 0;
    logic [7:0] bus_wdata = 0;
    logic [7:0] bus_rdata;
    logic       ext_pin = 0;
    logic       irq;

    int checks = 0, failures = 0;
    int irq_cycles = 0;
    int cyc = 0;
    int last_irq = -1, prev_irq = -1;

    // Reference model state
    int m_cnt, m_lat, m_irq;

    reload_timer16 u_reload_timer16 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ext_pin(ext_pin), .irq(irq)
    );

    always #5 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (rst_n && irq) begin
            irq_cycles <= irq_cycles + 1;
            prev_irq <= last_irq;
            last_irq <= cyc;
        end
    end

    initial begin
        #1500000;
        failures++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wreg(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1 bus_wr = 0; bus_addr = 3;
    endtask

    task automatic w16(input int v);
        wreg(0, v[7:0]);
        wreg(1, v[15:8]);
    endtask

    task automatic r16(output int v);
        logic [7:0] hi, lo;
        @(negedge clk);
        bus_rd = 1; bus_addr = 1; #1 hi = bus_rdata;
        @(posedge clk); #1 bus_rd = 0; bus_addr = 0; #1 lo = bus_rdata;
        bus_addr = 3;
        v = {hi, lo};
    endtask

    task automatic pulse();
        @(negedge clk); ext_pin = 1;
        repeat (4) @(negedge clk);
        ext_pin = 0;
        repeat (4) @(negedge clk);
    endtask

    // Model of one count pulse (running, no write in that cycle)
    function automatic void model_step();
        if (m_cnt == 0) begin m_cnt = m_lat; m_irq++; end
        else m_cnt = m_cnt - 1;
    endfunction

    initial begin
        int v, base, n;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        r16(v); check("R1 counter", v, 16'hFFFF);
        @(negedge clk); bus_addr = 2; #1 check("R1 ctrl", bus_rdata, 8'h01);
        check("R1 irq", irq, 0);
        bus_addr = 3;

        // R11 control readback, upper bits zero
        wreg(2, 8'hF3);
        @(negedge clk); bus_addr = 2; #1 check("R11 ctrl", bus_rdata, 8'h03); bus_addr = 3;

        // R8 low write alone has no effect (stopped, ext source)
        wreg(0, 8'h55);
        r16(v); check("R8 low write held", v, 16'hFFFF);
        wreg(1, 8'h01);
        r16(v); check("R8 commit", v, 16'h0155);
        m_cnt = 16'h0155; m_lat = 16'h0155; m_irq = 0;

        // R4 stop holds under pulses
        base = irq_cycles;
        repeat (3) pulse();
        r16(v); check("R4 stop hold", v, m_cnt);
        check("R4 no irq", irq_cycles - base, 0);

        // R2 run, rising edge, external
        wreg(2, 8'h02);
        w16(16'h0100); m_cnt = 16'h0100; m_lat = 16'h0100;
        // R7 coherent read: capture, then counter moves
        @(negedge clk); bus_rd = 1; bus_addr = 1; #1 check("R7 high", bus_rdata, 8'h01);
        @(posedge clk); #1 bus_rd = 0; bus_addr = 3;
        pulse(); model_step();
        @(negedge clk); bus_addr = 0; #1 check("R7 captured low", bus_rdata, 8'h00); bus_addr = 3;
        r16(v); check("R2 decrement", v, 16'h00FF);

        // R6 falling-edge mode: rising half ignored
        wreg(2, 8'h06);
        @(negedge clk); ext_pin = 1; repeat (5) @(negedge clk);
        r16(v); check("R6 rising ignored", v, m_cnt);
        ext_pin = 0; repeat (5) @(negedge clk); model_step();
        r16(v); check("R6 falling counts", v, m_cnt);

        // R3 underflow reload and single irq pulse
        wreg(2, 8'h02);
        w16(16'h0001); m_cnt = 1; m_lat = 1;
        base = irq_cycles; m_irq = 0;
        repeat (3) begin pulse(); model_step(); end
        r16(v); check("R3 reload", v, m_cnt);
        check("R3 irq pulses", irq_cycles - base, m_irq);

        // R9 latch-only write
        wreg(2, 8'h0A);
        w16(16'h0004); m_lat = 4;
        r16(v); check("R9 counter kept", v, m_cnt);
        wreg(2, 8'h02);
        while (m_cnt != 4 || m_irq == 1) begin
            pulse(); model_step();
            if (m_cnt == 4) break;
        end
        r16(v); check("R9 reload uses new latch", v, 4);

        // R10 collision: commit on the same edge as an underflowing pulse
        w16(16'h0000); m_cnt = 0; m_lat = 0;
        wreg(0, 8'h77);
        base = irq_cycles;
        @(negedge clk); ext_pin = 1;
        @(negedge clk);
        @(negedge clk); bus_wr = 1; bus_addr = 1; bus_wdata = 8'h00;
        @(posedge clk); #1 bus_wr = 0; bus_addr = 3;
        repeat (4) @(negedge clk); ext_pin = 0; repeat (4) @(negedge clk);
        r16(v); check("R10 write wins", v, 16'h0077);
        check("R10 no irq", irq_cycles - base, 0);
        m_cnt = 16'h77; m_lat = 16'h77;

        // Random mix, rising edge external
        for (int i = 0; i < 24; i++) begin
            if ($urandom_range(0, 2) == 0) begin
                v = $urandom_range(0, 5);
                w16(v); m_cnt = v; m_lat = v;
            end else begin
                n = $urandom_range(1, 4);
                base = irq_cycles; m_irq = 0;
                for (int k = 0; k < n; k++) begin pulse(); model_step(); end
                check("R3 random irq", irq_cycles - base, m_irq);
            end
            r16(v); check("R2 random count", v, m_cnt);
        end

        // R5 internal source period
        wreg(2, 8'h01);
        w16(16'h0003);
        wreg(2, 8'h00);
        base = irq_cycles;
        while (irq_cycles - base < 3) @(negedge clk);
        check("R5 period", last_irq - prev_irq, 64);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule